// File: doc/BRIEF.md
# Storage controller address decoder

This block sits in front of a two-channel storage controller and steers each I/O access to the right register block. It holds five programmable address windows: a command block and a control block for each of the two channels, and one shared window for the bus-master registers. Each access is compared against the windows in a fixed priority order. The base of the first matching window is subtracted from the address, and the access goes out on one forward port, tagged with its channel, its region and its local offset.

The bus-master window serves both channels. Its lower eight bytes belong to the primary channel, and the upper part belongs to the secondary channel, with the offset rebased to zero. Writes into that window are dropped while bus mastering is disabled. For each channel the block keeps a device-select bit, taken from writes it observes to a fixed offset of that channel's command block. Every request gets a response on the next cycle. The response carries the read data returned by the selected channel, or all-ones when no channel was read. Accesses of an illegal size and accesses that hit no window are flagged as errors.

Top module: `sctl_addr_router`

## Requirements
- R1: After reset every window has size zero. Any access of legal size with I/O enabled therefore gets rsp_err, and both device-select outputs are 0.
- R2: Only req_size values 1, 2 and 4 are legal. Any other value gives rsp_err=1 and fwd_valid=0, whatever the enables and the address.
- R3: When io_en is 0, a legal access gives fwd_valid=0 and rsp_err=0, with read data all-ones. It does not change any device-select bit.
- R4: A window matches when base <= addr < base+size. Windows are tried in the order primary command (0), primary control (1), secondary command (2), secondary control (3), bus-master (4), and the lowest-numbered match wins. fwd_offset is addr minus the base. fwd_region is 0 for command, 1 for control and 2 for bus-master. fwd_chan is 0 for primary and 1 for secondary.
- R5: Inside the bus-master window, local offsets below 8 go to channel 0 unchanged. Offsets of 8 and above go to channel 1, with 8 subtracted.
- R6: While bm_en is 0, a write that matches the bus-master window is dropped (fwd_valid=0, rsp_err=0). Reads of that window are still forwarded.
- R7: A forwarded write to command-block offset 6 loads that channel's device-select output from bit 4 of req_wdata. Reads, other offsets and other regions leave it unchanged.
- R8: With io_en high, a legal access that matches no window gives rsp_err=1 and read data all-ones.
- R9: A config write (cfg_we) addresses window cfg_win, numbered as in R4. With cfg_is_size=1 it loads that window's size with cfg_data, zero included. With cfg_is_size=0 it loads the base, but only when cfg_data is nonzero.
- R10: fwd_* reflect the current request in the same cycle. rsp_valid follows req_valid one cycle later. rsp_rdata carries the forwarded channel's rdata sampled in the request cycle for a forwarded read, and all-ones otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Window configuration write strobe |
| cfg_win | input | 3 | Window index for the configuration write |
| cfg_is_size | input | 1 | 1 writes the size, 0 writes the base |
| cfg_data | input | AW | Base or size value |
| io_en | input | 1 | I/O decoding enable |
| bm_en | input | 1 | Bus-master write enable |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Access address |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | DW | Write data |
| pri_rdata | input | DW | Read data from the primary channel |
| sec_rdata | input | DW | Read data from the secondary channel |
| fwd_valid | output | 1 | Access forwarded to a channel |
| fwd_chan | output | 1 | Target channel (0 primary, 1 secondary) |
| fwd_region | output | 2 | Target region (0 command, 1 control, 2 bus-master) |
| fwd_offset | output | AW | Local offset within the region |
| fwd_write | output | 1 | Forwarded direction |
| fwd_size | output | 3 | Forwarded size |
| fwd_wdata | output | DW | Forwarded write data |
| rsp_valid | output | 1 | Response, one cycle after the request |
| rsp_err | output | 1 | Illegal size or no window matched |
| rsp_rdata | output | DW | Response read data |
| pri_dev_sel | output | 1 | Primary channel device-select bit |
| sec_dev_sel | output | 1 | Secondary channel device-select bit |

## Verification
Priority only shows when two windows overlap, and a correct configuration never overlaps them. The bench therefore moves the primary control window on top of the primary command window, probes addresses in the shared range and just past it, and then restores it. Device-select updates are harder still to reach by chance: they need a forwarded write to exactly offset 6 of a command window with I/O enabled. Directed writes cover both bit values, a read, a neighbouring offset and the I/O-disabled case, while random traffic around the window edges mixes sizes and the enable inputs.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

    localparam int NWIN      = 5;
    localparam int WIN_PCMD  = 0;
    localparam int WIN_PCTL  = 1;
    localparam int WIN_SCMD  = 2;
    localparam int WIN_SCTL  = 3;
    localparam int WIN_BM    = 4;

    typedef enum logic [1:0] {
        RGN_CMD  = 2'd0,
        RGN_CTRL = 2'd1,
        RGN_BM   = 2'd2
    } region_e;

    typedef struct packed {
        logic    hit;
        logic    chan;
        region_e rgn;
    } route_t;

    function automatic logic size_ok(input logic [2:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

    function automatic logic win_chan(input int w);
        return (w == WIN_SCMD) || (w == WIN_SCTL);
    endfunction

    function automatic region_e win_rgn(input int w);
        case (w)
            WIN_PCMD, WIN_SCMD: return RGN_CMD;
            WIN_PCTL, WIN_SCTL: return RGN_CTRL;
            default:            return RGN_BM;
        endcase
    endfunction

endpackage

// File: rtl/sctl_win_regs.sv
module sctl_win_regs
    import sctl_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [2:0]               cfg_win,
    input  logic                     cfg_is_size,
    input  logic [AW-1:0]            cfg_data,
    output logic [NWIN-1:0][AW-1:0]  base_o,
    output logic [NWIN-1:0][AW-1:0]  size_o
);

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        logic sel;
        assign sel = cfg_we && (cfg_win == 3'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                base_o[w] <= '0;
                size_o[w] <= '0;
            end else if (sel) begin
                if (cfg_is_size)
                    size_o[w] <= cfg_data;
                else if (cfg_data != '0)
                    base_o[w] <= cfg_data;
            end
        end
    end

endmodule

// File: rtl/sctl_win_match.sv
module sctl_win_match
    import sctl_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0]            addr,
    input  logic [NWIN-1:0][AW-1:0]  base_i,
    input  logic [NWIN-1:0][AW-1:0]  size_i,
    output logic [NWIN-1:0]          hit_o,
    output logic [NWIN-1:0][AW-1:0]  ofs_o
);

    localparam int EW = AW + 1;

    for (genvar w = 0; w < NWIN; w++) begin : g_cmp
        logic [EW-1:0] limit;
        assign limit    = {1'b0, base_i[w]} + {1'b0, size_i[w]};
        assign hit_o[w] = (addr >= base_i[w]) && ({1'b0, addr} < limit);
        assign ofs_o[w] = addr - base_i[w];
    end

endmodule

// File: rtl/sctl_prio_route.sv
module sctl_prio_route
    import sctl_pkg::*;
#(
    parameter int AW       = 16,
    parameter int BM_SPLIT = 8
) (
    input  logic [NWIN-1:0]          hit_i,
    input  logic [NWIN-1:0][AW-1:0]  ofs_i,
    output route_t                   route_o,
    output logic [AW-1:0]            ofs_o
);

    localparam logic [AW-1:0] SPLIT = AW'(BM_SPLIT);

    int            win;
    logic [AW-1:0] raw_ofs;

    always_comb begin
        win = 0;
        route_o.hit = 1'b0;
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (hit_i[w]) begin
                win = w;
                route_o.hit = 1'b1;
            end
        end
        raw_ofs      = ofs_i[win];
        route_o.chan = win_chan(win);
        route_o.rgn  = win_rgn(win);
        ofs_o        = raw_ofs;
        if (route_o.rgn == RGN_BM && raw_ofs >= SPLIT) begin
            route_o.chan = 1'b1;
            ofs_o        = raw_ofs - SPLIT;
        end
    end

endmodule

// File: rtl/sctl_devsel.sv
module sctl_devsel #(
    parameter int AW      = 16,
    parameter int SEL_OFS = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_cmd,
    input  logic          chan,
    input  logic [AW-1:0] offset,
    input  logic          sel_bit,
    output logic [1:0]    dev_sel
);

    localparam logic [AW-1:0] OFS = AW'(SEL_OFS);

    for (genvar c = 0; c < 2; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)
                dev_sel[c] <= 1'b0;
            else if (wr_cmd && (chan == 1'(c)) && (offset == OFS))
                dev_sel[c] <= sel_bit;
        end
    end

endmodule

// File: rtl/sctl_addr_router.sv
module sctl_addr_router
    import sctl_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 32,
    parameter int BM_SPLIT = 8,
    parameter int SEL_OFS  = 6,
    parameter int SEL_BIT  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_win,
    input  logic          cfg_is_size,
    input  logic [AW-1:0] cfg_data,
    input  logic          io_en,
    input  logic          bm_en,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [2:0]    req_size,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] pri_rdata,
    input  logic [DW-1:0] sec_rdata,
    output logic          fwd_valid,
    output logic          fwd_chan,
    output logic [1:0]    fwd_region,
    output logic [AW-1:0] fwd_offset,
    output logic          fwd_write,
    output logic [2:0]    fwd_size,
    output logic [DW-1:0] fwd_wdata,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic [DW-1:0] rsp_rdata,
    output logic          pri_dev_sel,
    output logic          sec_dev_sel
);

    logic [NWIN-1:0][AW-1:0] win_base;
    logic [NWIN-1:0][AW-1:0] win_size;
    logic [NWIN-1:0]         win_hit;
    logic [NWIN-1:0][AW-1:0] win_ofs;
    route_t                  route;
    logic [AW-1:0]           route_ofs;
    logic                    legal;
    logic                    bm_drop;
    logic                    err_now;
    logic [DW-1:0]           rdata_now;
    logic [1:0]              dsel;

    sctl_win_regs #(.AW(AW)) regs_i (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_win     (cfg_win),
        .cfg_is_size (cfg_is_size),
        .cfg_data    (cfg_data),
        .base_o      (win_base),
        .size_o      (win_size)
    );

    sctl_win_match #(.AW(AW)) match_i (
        .addr   (req_addr),
        .base_i (win_base),
        .size_i (win_size),
        .hit_o  (win_hit),
        .ofs_o  (win_ofs)
    );

    sctl_prio_route #(.AW(AW), .BM_SPLIT(BM_SPLIT)) route_i (
        .hit_i   (win_hit),
        .ofs_i   (win_ofs),
        .route_o (route),
        .ofs_o   (route_ofs)
    );

    always_comb begin
        legal     = size_ok(req_size);
        bm_drop   = (route.rgn == RGN_BM) && req_write && !bm_en;
        fwd_valid = req_valid && legal && io_en && route.hit && !bm_drop;
        err_now   = req_valid && (!legal || (io_en && !route.hit));
        if (fwd_valid && !req_write)
            rdata_now = route.chan ? sec_rdata : pri_rdata;
        else
            rdata_now = '1;
    end

    assign fwd_chan   = route.chan;
    assign fwd_region = route.rgn;
    assign fwd_offset = route_ofs;
    assign fwd_write  = req_write;
    assign fwd_size   = req_size;
    assign fwd_wdata  = req_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '1;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= err_now;
            rsp_rdata <= rdata_now;
        end
    end

    sctl_devsel #(.AW(AW), .SEL_OFS(SEL_OFS)) devsel_i (
        .clk     (clk),
        .rst     (rst),
        .wr_cmd  (fwd_valid && req_write && (route.rgn == RGN_CMD)),
        .chan    (route.chan),
        .offset  (route_ofs),
        .sel_bit (req_wdata[SEL_BIT]),
        .dev_sel (dsel)
    );

    assign pri_dev_sel = dsel[0];
    assign sec_dev_sel = dsel[1];

endmodule

// File: rtl/sctl_addr_router_chk.sv
module sctl_addr_router_chk #(
    parameter int AW       = 16,
    parameter int DW       = 32,
    parameter int BM_SPLIT = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          io_en,
    input logic          bm_en,
    input logic          req_valid,
    input logic          req_write,
    input logic [2:0]    req_size,
    input logic          fwd_valid,
    input logic          fwd_chan,
    input logic [1:0]    fwd_region,
    input logic [AW-1:0] fwd_offset,
    input logic          fwd_write,
    input logic          rsp_valid,
    input logic          rsp_err,
    input logic [DW-1:0] rsp_rdata,
    input logic          pri_dev_sel,
    input logic          sec_dev_sel
);

    // R3
    io_gate_chk: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> io_en);

    // R2
    size_gate_chk: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> (req_size == 3'd1 || req_size == 3'd2 || req_size == 3'd4));

    // R6
    bm_write_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (fwd_valid && fwd_write && fwd_region == 2'd2) |-> bm_en);

    // R5
    bm_split_chk: assert property (@(posedge clk) disable iff (rst)
        (fwd_valid && fwd_region == 2'd2 && !fwd_chan) |-> (fwd_offset < AW'(BM_SPLIT)));

    // R10
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R10
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R8
    err_ones_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_rdata == {DW{1'b1}}));

    // R7
    devsel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write) |=> ($stable(pri_dev_sel) && $stable(sec_dev_sel)));

endmodule

bind sctl_addr_router sctl_addr_router_chk #(.AW(AW), .DW(DW), .BM_SPLIT(BM_SPLIT)) chk_i (.*);

// File: tb/sctl_addr_router_tb_top.sv
`timescale 1ns/1ps
module sctl_addr_router_tb_top;

    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_win = '0;
    logic          cfg_is_size = 1'b0;
    logic [AW-1:0] cfg_data = '0;
    logic          io_en = 1'b1;
    logic          bm_en = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [2:0]    req_size = 3'd1;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] pri_rdata = '0;
    logic [DW-1:0] sec_rdata = '0;
    logic          fwd_valid, fwd_chan, fwd_write;
    logic [1:0]    fwd_region;
    logic [AW-1:0] fwd_offset;
    logic [2:0]    fwd_size;
    logic [DW-1:0] fwd_wdata;
    logic          rsp_valid, rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic          pri_dev_sel, sec_dev_sel;

    always #2.5 clk = ~clk;

    sctl_addr_router dut_i (.*);

    int n_chk = 0;
    int n_fail = 0;
    int m_base [5];
    int m_size [5];
    logic m_dsel [2];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cfg(input int win, input bit is_size, input int data);
        cfg_we = 1'b1; cfg_win = 3'(win); cfg_is_size = is_size; cfg_data = AW'(data);
        @(posedge clk); #0;
        @(negedge clk);
        cfg_we = 1'b0;
        if (is_size) m_size[win] = data;
        else if (data != 0) m_base[win] = data;
    endtask

    task automatic predict(input bit wr, input int addr, input int sz,
                           output bit fv, output bit ch, output int rg,
                           output int ofs, output bit err);
        bit legal, hit;
        int w;
        legal = (sz == 1 || sz == 2 || sz == 4);
        hit = 0; w = 0;
        for (int i = 4; i >= 0; i--)
            if (addr >= m_base[i] && addr < m_base[i] + m_size[i]) begin
                hit = 1; w = i;
            end
        ofs = addr - m_base[w];
        ch  = (w == 2 || w == 3);
        rg  = (w == 4) ? 2 : ((w == 1 || w == 3) ? 1 : 0);
        if (rg == 2 && ofs >= 8) begin ch = 1; ofs = ofs - 8; end
        fv  = legal && io_en && hit && !(rg == 2 && wr && !bm_en);
        err = !legal || (io_en && !hit);
    endtask

    task automatic acc(input bit wr, input int addr, input int sz,
                       input logic [31:0] wd, input string tag);
        bit fv, ch, err;
        int rg, ofs;
        logic [31:0] erd;
        req_valid = 1'b1; req_write = wr; req_addr = AW'(addr);
        req_size = 3'(sz); req_wdata = wd;
        pri_rdata = $urandom; sec_rdata = $urandom;
        #1;
        predict(wr, addr, sz, fv, ch, rg, ofs, err);
        chk(fwd_valid == fv, tag, "fwd_valid", 32'(fwd_valid), 32'(fv));
        if (fv) begin
            chk(fwd_chan == ch, tag, "fwd_chan", 32'(fwd_chan), 32'(ch));
            chk(fwd_region == 2'(rg), tag, "fwd_region", 32'(fwd_region), 32'(rg));
            chk(fwd_offset == AW'(ofs), tag, "fwd_offset", 32'(fwd_offset), 32'(ofs));
        end
        erd = (fv && !wr) ? (ch ? sec_rdata : pri_rdata) : 32'hFFFF_FFFF;
        if (fv && wr && rg == 0 && ofs == 6) m_dsel[ch] = wd[4];
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R10", "rsp_valid", 32'(rsp_valid), 32'd1);
        chk(rsp_err == err, tag, "rsp_err", 32'(rsp_err), 32'(err));
        chk(rsp_rdata == erd, "R10", "rsp_rdata", rsp_rdata, erd);
        chk(pri_dev_sel == m_dsel[0], "R7", "pri_dev_sel", 32'(pri_dev_sel), 32'(m_dsel[0]));
        chk(sec_dev_sel == m_dsel[1], "R7", "sec_dev_sel", 32'(sec_dev_sel), 32'(m_dsel[1]));
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        process::self().srandom(32'd12345);
        for (int i = 0; i < 5; i++) begin m_base[i] = 0; m_size[i] = 0; end
        m_dsel[0] = 0; m_dsel[1] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(pri_dev_sel == 1'b0 && sec_dev_sel == 1'b0, "R1", "dev_sel after reset",
            {30'd0, sec_dev_sel, pri_dev_sel}, 32'd0);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        acc(0, 'h0, 1, 0, "R1");
        acc(1, 'h100, 1, 0, "R1");

        // R9: programming
        cfg(0, 0, 'h100); cfg(0, 1, 8);
        cfg(1, 0, 'h108); cfg(1, 1, 4);
        cfg(2, 0, 'h200); cfg(2, 1, 8);
        cfg(3, 0, 'h20C); cfg(3, 1, 4);
        cfg(4, 0, 'h300); cfg(4, 1, 16);
        cfg(0, 0, 0);
        acc(0, 'h100, 1, 0, "R9");
        acc(0, 'h0, 1, 0, "R9");

        // R4: window edges
        acc(0, 'h107, 1, 0, "R4");
        acc(0, 'h108, 2, 0, "R4");
        acc(0, 'h10B, 1, 0, "R4");
        acc(0, 'h203, 4, 0, "R4");
        acc(0, 'h20F, 1, 0, "R4");
        acc(0, 'h0FF, 1, 0, "R8");
        acc(0, 'h10C, 1, 0, "R8");
        acc(1, 'h310, 1, 0, "R8");

        // R4: priority when windows overlap
        cfg(1, 0, 'h104);
        acc(0, 'h105, 1, 0, "R4");
        acc(0, 'h109, 1, 0, "R4");
        cfg(1, 0, 'h108);

        // R5: bus-master split
        acc(0, 'h307, 1, 0, "R5");
        acc(0, 'h308, 1, 0, "R5");
        acc(0, 'h30F, 1, 0, "R5");

        // R6: bus-master writes gated
        bm_en = 1'b0;
        acc(1, 'h302, 1, 32'h55, "R6");
        acc(0, 'h302, 1, 0, "R6");
        acc(1, 'h104, 1, 32'h55, "R6");
        bm_en = 1'b1;
        acc(1, 'h30A, 1, 32'h55, "R6");

        // R7: device select snooping
        acc(1, 'h106, 1, 32'h10, "R7");
        acc(1, 'h206, 1, 32'h00, "R7");
        acc(1, 'h206, 1, 32'h10, "R7");
        acc(0, 'h106, 1, 0, "R7");
        acc(1, 'h105, 1, 32'h00, "R7");
        acc(1, 'h10A, 1, 32'h00, "R7");
        acc(1, 'h106, 2, 32'hEF, "R7");

        // R3: I/O disabled
        io_en = 1'b0;
        acc(1, 'h206, 1, 32'h00, "R3");
        acc(0, 'h300, 4, 0, "R3");
        acc(0, 'h900, 1, 0, "R3");
        io_en = 1'b1;

        // R2: illegal sizes
        acc(0, 'h100, 3, 0, "R2");
        acc(1, 'h106, 0, 32'h10, "R2");
        acc(0, 'h300, 5, 0, "R2");
        io_en = 1'b0;
        acc(0, 'h100, 7, 0, "R2");
        io_en = 1'b1;

        // Random traffic around the windows
        for (int i = 0; i < 400; i++) begin
            int w, bases [5];
            bases = '{'h100, 'h108, 'h200, 'h20C, 'h300};
            w = $urandom_range(4, 0);
            io_en = ($urandom_range(9, 0) != 0);
            bm_en = $urandom_range(1, 0);
            acc($urandom_range(1, 0), bases[w] + $urandom_range(19, 0) - 2,
                ($urandom_range(4, 0) == 0) ? $urandom_range(7, 0) : (1 << $urandom_range(2, 0)),
                ($urandom_range(1, 0) != 0) ? 32'h10 : $urandom, "R4");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule